// File: doc/BRIEF.md
# Light-Sensor Register Slave on a Two-Wire Bus

This block is the host-facing register bank of an ambient-light sensor controller. It listens on a two-wire I2C bus as a slave with a fixed 7-bit address, decodes START, repeated START and STOP conditions, and serves eight byte-wide registers. Four of them are writable: a command register, a control register and two threshold registers. The other four are read-only copies of the latest sensor result and the matching timer count. The conversion logic loads these copies through a parallel load port.

Every write transfer begins with a pointer byte. The low three bits of that byte select a register. Bits 7 and 6 of the same byte are command strobes. Bit 7 ends the current integration and starts a new one, and bit 6 clears the interrupt. Each strobe appears as a one-cycle pulse on the system-clock side.

The configuration fields drive the conversion logic directly. The interrupt flag is set by the conversion logic and cleared only by the clear strobe. Both bus lines pass through a synchronizer before any edge is detected. The slave never stretches the clock.

Top module: `lux_i2c_regs`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth bit) only an address byte whose upper seven bits equal 0x44. A byte with any other address is not acknowledged, and the rest of that transfer changes no register.
- R2: A write sends the address byte with R/W=0, then a pointer byte, then data bytes. Bits 2:0 of the pointer byte select the register. Each data byte is acknowledged, and after each one the pointer advances by one, wrapping from 7 to 0.
- R3: A read sends an address write with the pointer byte, then a repeated START and the address byte with R/W=1. Bytes go out MSB first, the pointer advances after each byte with the same wrap, and a master NAK ends the read.
- R4: Register 0 (command) drives the outputs: bit 7 enable, bit 6 power-down, bit 5 external timing, bits 3:2 diode select, bits 1:0 width. Bit 4 is stored as 0 and reads back 0.
- R5: Register 1 (control) drives the outputs gain (bits 3:2) and persistence (bits 1:0). Bits 7, 6 and 4 read back 0. Bit 5 reads the interrupt flag, and a bus write does not change it.
- R6: Register 2 (high threshold) resets to 0xFF and register 3 (low threshold) resets to 0x00. Both drive their outputs.
- R7: A one-cycle dataLoad captures sensorIn and timerIn. Register 4 returns the sensor low byte, register 5 the sensor high byte, register 6 the timer low byte and register 7 the timer high byte. Writes to registers 4 to 7 are acknowledged but change nothing.
- R8: A pointer byte with bit 7 set produces exactly one one-cycle syncPulse. A pointer byte with bit 6 set produces exactly one one-cycle clrIntPulse. Both bits set produce both pulses, with or without data bytes after the pointer.
- R9: intSet sets intFlag. The clear strobe clears it, and the clear wins when both happen in the same cycle.
- R10: Configuration and threshold values hold until they are overwritten by a bus write, and they change only while SCL is low.
- R11: After reset, all configuration outputs are 0, thresholds are 0xFF/0x00, intFlag is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | 1 = drive the data line low (open-drain enable) |
| cfgEnable | output | 1 | Command bit 7, converter enable |
| cfgPowerDown | output | 1 | Command bit 6, power-down |
| cfgExtTiming | output | 1 | Command bit 5, bus-timed integration |
| cfgDiodeSel | output | 2 | Command bits 3:2, photodiode selection |
| cfgWidth | output | 2 | Command bits 1:0, conversion width code |
| cfgGain | output | 2 | Control bits 3:2, range select |
| cfgPersist | output | 2 | Control bits 1:0, interrupt persistence code |
| thrHigh | output | 8 | High threshold byte |
| thrLow | output | 8 | Low threshold byte |
| dataLoad | input | 1 | Capture strobe for sensorIn and timerIn |
| sensorIn | input | 16 | Latest sensor result |
| timerIn | input | 16 | Timer count for that result |
| intSet | input | 1 | Interrupt trigger from the conversion logic |
| intFlag | output | 1 | Interrupt flag |
| syncPulse | output | 1 | One-cycle integration-sync strobe |
| clrIntPulse | output | 1 | One-cycle interrupt-clear strobe |

## Verification
The bench builds the block with its default parameters: the 0x44 address, a two-flop synchronizer and the 0xFF/0x00 threshold reset values. Using the real address lets the bench test a neighbouring address byte for a NAK. The default threshold values make the reset readback distinct from anything the bench writes. With the two-stage synchronizer and a bus bit of 32 system cycles, acknowledge and data bits settle well inside each SCL-high window. This leaves room to check pointer wrap in both directions, strobes issued with and without data bytes, and the interrupt-flag write protection.

// File: rtl/luxRegsPkg.sv
package luxRegsPkg;
  localparam int REG_W = 8;
  localparam int PTR_W = 3;
  localparam int WORD_W = 2 * REG_W;

  localparam logic [PTR_W-1:0] REG_CMD  = 3'd0;
  localparam logic [PTR_W-1:0] REG_CTRL = 3'd1;
  localparam logic [PTR_W-1:0] REG_THRH = 3'd2;
  localparam logic [PTR_W-1:0] REG_THRL = 3'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrAddr;
    logic [REG_W-1:0] wrData;
    logic             syncCmd;
    logic             clrCmd;
  } regStrobe_t;
endpackage

// File: rtl/luxBusSync.sv
module luxBusSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= din;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/luxI2cCtrl.sv
module luxI2cCtrl
  import luxRegsPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic [REG_W-1:0] rdData,
  output regStrobe_t       strobe,
  output logic [PTR_W-1:0] rdAddr,
  output logic             sdaPullLow
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic sclD, sdaD;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state;
  logic [3:0] bitCnt;
  logic [REG_W-1:0] shiftIn, txShift;
  logic [PTR_W-1:0] ptr;
  logic rdMode, nackSeen;

  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
  assign rdAddr  = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftIn    <= '0;
      txShift    <= '0;
      ptr        <= '0;
      rdMode     <= 1'b0;
      nackSeen   <= 1'b0;
      sdaPullLow <= 1'b0;
      strobe     <= '0;
    end else begin
      strobe.wrEn    <= 1'b0;
      strobe.syncCmd <= 1'b0;
      strobe.clrCmd  <= 1'b0;
      if (startEv) begin
        state      <= ST_DEV;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopEv) begin
        state      <= ST_IDLE;
        sdaPullLow <= 1'b0;
      end else begin
        if (sclRise) begin
          case (state)
            ST_DEV, ST_PTR, ST_WR:
              if (bitCnt < BITS_PER_BYTE) begin
                shiftIn <= {shiftIn[REG_W-2:0], sdaS};
                bitCnt  <= bitCnt + 4'd1;
              end
            ST_RD:     bitCnt   <= bitCnt + 4'd1;
            ST_RD_ACK: nackSeen <= sdaS;
            default: ;
          endcase
        end
        if (sclFall) begin
          case (state)
            ST_DEV:
              if (bitCnt == BITS_PER_BYTE) begin
                if (shiftIn[7:1] == DEV_ADDR) begin
                  state      <= ST_DEV_ACK;
                  rdMode     <= shiftIn[0];
                  sdaPullLow <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
            ST_DEV_ACK: begin
              bitCnt <= '0;
              if (rdMode) begin
                state      <= ST_RD;
                txShift    <= {rdData[REG_W-2:0], 1'b0};
                sdaPullLow <= ~rdData[REG_W-1];
              end else begin
                state      <= ST_PTR;
                sdaPullLow <= 1'b0;
              end
            end
            ST_PTR:
              if (bitCnt == BITS_PER_BYTE) begin
                ptr            <= shiftIn[PTR_W-1:0];
                strobe.syncCmd <= shiftIn[7];
                strobe.clrCmd  <= shiftIn[6];
                state          <= ST_PTR_ACK;
                sdaPullLow     <= 1'b1;
              end
            ST_PTR_ACK, ST_WR_ACK: begin
              state      <= ST_WR;
              bitCnt     <= '0;
              sdaPullLow <= 1'b0;
            end
            ST_WR:
              if (bitCnt == BITS_PER_BYTE) begin
                strobe.wrEn   <= 1'b1;
                strobe.wrAddr <= ptr;
                strobe.wrData <= shiftIn;
                ptr           <= ptr + 1'b1;
                state         <= ST_WR_ACK;
                sdaPullLow    <= 1'b1;
              end
            ST_RD:
              if (bitCnt == BITS_PER_BYTE) begin
                sdaPullLow <= 1'b0;
                ptr        <= ptr + 1'b1;
                state      <= ST_RD_ACK;
              end else begin
                sdaPullLow <= ~txShift[REG_W-1];
                txShift    <= {txShift[REG_W-2:0], 1'b0};
              end
            ST_RD_ACK:
              if (nackSeen) begin
                state      <= ST_IDLE;
                sdaPullLow <= 1'b0;
              end else begin
                state      <= ST_RD;
                bitCnt     <= '0;
                txShift    <= {rdData[REG_W-2:0], 1'b0};
                sdaPullLow <= ~rdData[REG_W-1];
              end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/luxRegBank.sv
module luxRegBank
  import luxRegsPkg::*;
#(
  parameter logic [REG_W-1:0] THR_HI_INIT = 8'hFF,
  parameter logic [REG_W-1:0] THR_LO_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              dataLoad,
  input  logic [WORD_W-1:0] sensorIn,
  input  logic [WORD_W-1:0] timerIn,
  input  logic              intSet,
  output logic              intFlag,
  output logic [REG_W-1:0]  cmdReg,
  output logic [3:0]        ctrlCfg,
  output logic [REG_W-1:0]  thrHi,
  output logic [REG_W-1:0]  thrLo,
  output logic              syncPulse,
  output logic              clrIntPulse
);
  localparam int RO_WORDS = 2;
  localparam logic [REG_W-1:0] CMD_MASK = 8'hEF;

  logic [WORD_W-1:0] roIn   [RO_WORDS];
  logic [WORD_W-1:0] roWord [RO_WORDS];

  assign roIn[0] = sensorIn;
  assign roIn[1] = timerIn;

  genvar g;
  generate
    for (g = 0; g < RO_WORDS; g++) begin : gRoWord
      always_ff @(posedge clk or negedge rstN)
        if (!rstN)         roWord[g] <= '0;
        else if (dataLoad) roWord[g] <= roIn[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      ctrlCfg <= '0;
      thrHi   <= THR_HI_INIT;
      thrLo   <= THR_LO_INIT;
    end else if (strobe.wrEn) begin
      case (strobe.wrAddr)
        REG_CMD:  cmdReg  <= strobe.wrData & CMD_MASK;
        REG_CTRL: ctrlCfg <= strobe.wrData[3:0];
        REG_THRH: thrHi   <= strobe.wrData;
        REG_THRL: thrLo   <= strobe.wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag     <= 1'b0;
      syncPulse   <= 1'b0;
      clrIntPulse <= 1'b0;
    end else begin
      syncPulse   <= strobe.syncCmd;
      clrIntPulse <= strobe.clrCmd;
      if (strobe.clrCmd) intFlag <= 1'b0;
      else if (intSet)   intFlag <= 1'b1;
    end
  end

  always_comb begin
    case (rdAddr)
      3'd0: rdData = cmdReg;
      3'd1: rdData = {2'b00, intFlag, 1'b0, ctrlCfg};
      3'd2: rdData = thrHi;
      3'd3: rdData = thrLo;
      3'd4: rdData = roWord[0][REG_W-1:0];
      3'd5: rdData = roWord[0][WORD_W-1:REG_W];
      3'd6: rdData = roWord[1][REG_W-1:0];
      default: rdData = roWord[1][WORD_W-1:REG_W];
    endcase
  end
endmodule

// File: rtl/lux_i2c_regs.sv
module lux_i2c_regs
  import luxRegsPkg::*;
#(
  parameter logic [6:0]       DEV_ADDR    = 7'h44,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] THR_HI_INIT = 8'hFF,
  parameter logic [REG_W-1:0] THR_LO_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic              cfgEnable,
  output logic              cfgPowerDown,
  output logic              cfgExtTiming,
  output logic [1:0]        cfgDiodeSel,
  output logic [1:0]        cfgWidth,
  output logic [1:0]        cfgGain,
  output logic [1:0]        cfgPersist,
  output logic [REG_W-1:0]  thrHigh,
  output logic [REG_W-1:0]  thrLow,
  input  logic              dataLoad,
  input  logic [WORD_W-1:0] sensorIn,
  input  logic [WORD_W-1:0] timerIn,
  input  logic              intSet,
  output logic              intFlag,
  output logic              syncPulse,
  output logic              clrIntPulse
);
  logic sclS, sdaS;
  regStrobe_t strobe;
  logic [PTR_W-1:0] rdAddr;
  logic [REG_W-1:0] rdData;
  logic [REG_W-1:0] cmdReg;
  logic [3:0] ctrlCfg;

  luxBusSync #(.STAGES(SYNC_STAGES)) uSclSync (.clk(clk), .rstN(rstN), .din(scl),   .dout(sclS));
  luxBusSync #(.STAGES(SYNC_STAGES)) uSdaSync (.clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  luxI2cCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .rdData(rdData),
    .strobe(strobe), .rdAddr(rdAddr), .sdaPullLow(sdaPullLow)
  );

  luxRegBank #(.THR_HI_INIT(THR_HI_INIT), .THR_LO_INIT(THR_LO_INIT)) uBank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .rdData(rdData),
    .dataLoad(dataLoad), .sensorIn(sensorIn), .timerIn(timerIn),
    .intSet(intSet), .intFlag(intFlag), .cmdReg(cmdReg), .ctrlCfg(ctrlCfg),
    .thrHi(thrHigh), .thrLo(thrLow), .syncPulse(syncPulse), .clrIntPulse(clrIntPulse)
  );

  assign cfgEnable    = cmdReg[7];
  assign cfgPowerDown = cmdReg[6];
  assign cfgExtTiming = cmdReg[5];
  assign cfgDiodeSel  = cmdReg[3:2];
  assign cfgWidth     = cmdReg[1:0];
  assign cfgGain      = ctrlCfg[3:2];
  assign cfgPersist   = ctrlCfg[1:0];
endmodule

// File: rtl/lux_i2c_regs_chk.sv
module lux_i2c_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaPullLow,
  input logic [7:0] thrHigh,
  input logic [7:0] thrLow,
  input logic [1:0] cfgGain,
  input logic       intSet,
  input logic       intFlag,
  input logic       syncPulse,
  input logic       clrIntPulse
);
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse); // R8
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    clrIntPulse |=> !clrIntPulse); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrIntPulse |-> !intFlag); // R9
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    intSet |=> (intFlag || clrIntPulse)); // R9
  AST_THRH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(thrHigh) |-> !scl); // R10
  AST_THRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(thrLow) |-> !scl); // R10
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgGain) |-> !scl); // R10
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !scl); // R1
  AST_RESET_RELEASE: assert property (@(posedge clk)
    !rstN |=> (!sdaPullLow && !intFlag && thrHigh == 8'hFF)); // R11
endmodule

bind lux_i2c_regs lux_i2c_regs_chk uChk (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaPullLow(sdaPullLow),
  .thrHigh(thrHigh), .thrLow(thrLow), .cfgGain(cfgGain), .intSet(intSet),
  .intFlag(intFlag), .syncPulse(syncPulse), .clrIntPulse(clrIntPulse)
);

// File: tb/tb_lux_i2c_regs.sv
`timescale 1ns/1ps
module tb_lux_i2c_regs;
  localparam int Q = 8;
  localparam logic [7:0] WR_ADDR = 8'h88;
  localparam logic [7:0] RD_ADDR = 8'h89;
  // {pointer, write data, expected readback}
  localparam logic [23:0] VEC [0:5] = '{
    {8'h00, 8'hBF, 8'hAF},
    {8'h01, 8'hFF, 8'h0F},
    {8'h02, 8'h3C, 8'h3C},
    {8'h03, 8'hC3, 8'hC3},
    {8'h04, 8'h77, 8'h34},
    {8'h07, 8'h99, 8'hAB}
  };

  logic clk = 0, rstN = 0;
  logic sclM = 1, sdaM = 1;
  logic sdaPullLow, cfgEnable, cfgPowerDown, cfgExtTiming;
  logic [1:0] cfgDiodeSel, cfgWidth, cfgGain, cfgPersist;
  logic [7:0] thrHigh, thrLow;
  logic dataLoad = 0, intSet = 0, intFlag, syncPulse, clrIntPulse;
  logic [15:0] sensorIn = 0, timerIn = 0;
  logic sdaLine;
  int errors = 0, checks = 0, syncCnt = 0, clrCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  lux_i2c_regs dut (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .cfgEnable(cfgEnable), .cfgPowerDown(cfgPowerDown), .cfgExtTiming(cfgExtTiming),
    .cfgDiodeSel(cfgDiodeSel), .cfgWidth(cfgWidth), .cfgGain(cfgGain),
    .cfgPersist(cfgPersist), .thrHigh(thrHigh), .thrLow(thrLow), .dataLoad(dataLoad),
    .sensorIn(sensorIn), .timerIn(timerIn), .intSet(intSet), .intFlag(intFlag),
    .syncPulse(syncPulse), .clrIntPulse(clrIntPulse)
  );

  always @(posedge clk) begin
    if (syncPulse)   syncCnt <= syncCnt + 1;
    if (clrIntPulse) clrCnt  <= clrCnt + 1;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1; waitc(Q); sclM = 1; waitc(Q); sdaM = 0; waitc(Q); sclM = 0; waitc(Q);
  endtask

  task automatic busStop();
    sdaM = 0; waitc(Q); sclM = 1; waitc(Q); sdaM = 1; waitc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitc(Q); sclM = 1; waitc(2*Q); sclM = 0; waitc(Q);
    end
    sdaM = 1; waitc(Q); sclM = 1; waitc(Q); ack = ~sdaLine; waitc(Q); sclM = 0; waitc(Q);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaM = 1;
    for (int i = 0; i < 8; i++) begin
      waitc(Q); sclM = 1; waitc(Q); b = {b[6:0], sdaLine}; waitc(Q); sclM = 0;
    end
    waitc(Q); sdaM = nack; waitc(Q); sclM = 1; waitc(2*Q); sclM = 0; waitc(Q); sdaM = 1;
  endtask

  task automatic writeOne(input logic [7:0] ptr, input logic [7:0] d, input string req);
    logic a;
    busStart(); sendByte(WR_ADDR, a); check(req, a, 1);
    sendByte(ptr, a); sendByte(d, a); check(req, a, 1); busStop();
  endtask

  task automatic readTwo(input logic [7:0] ptr, output logic [7:0] d0, output logic [7:0] d1);
    logic a;
    busStart(); sendByte(WR_ADDR, a); sendByte(ptr, a);
    busStart(); sendByte(RD_ADDR, a); recvByte(0, d0); recvByte(1, d1); busStop();
  endtask

  task automatic readOne(input logic [7:0] ptr, output logic [7:0] d);
    logic a;
    busStart(); sendByte(WR_ADDR, a); sendByte(ptr, a);
    busStart(); sendByte(RD_ADDR, a); recvByte(1, d); busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0, d1;
    logic a;
    int s0, c0;
    waitc(5); rstN = 1; waitc(5);
    // R11 reset state
    check("R11 cfg", {cfgEnable, cfgPowerDown, cfgExtTiming, cfgDiodeSel, cfgWidth, cfgGain, cfgPersist}, 0);
    check("R11 sda", sdaPullLow, 0);
    check("R11 flag", intFlag, 0);
    check("R6 reset thrHigh", thrHigh, 8'hFF);
    check("R6 reset thrLow", thrLow, 8'h00);
    readOne(8'h02, d0); check("R6 read thrHigh", d0, 8'hFF);

    // R7 load read-only words
    sensorIn = 16'h1234; timerIn = 16'hABCD; dataLoad = 1; waitc(1); dataLoad = 0;
    sensorIn = 16'h0; timerIn = 16'h0; waitc(2);

    for (int i = 0; i < 6; i++) begin
      writeOne(VEC[i][23:16], VEC[i][15:8], "R2 write ack");
      readOne(VEC[i][23:16], d0);
      check($sformatf("R3 R4 R5 R7 readback ptr %0d", VEC[i][23:16]), d0, VEC[i][7:0]);
    end
    check("R4 fields", {cfgEnable, cfgPowerDown, cfgExtTiming, cfgDiodeSel, cfgWidth}, 7'b1011111);
    check("R5 fields", {cfgGain, cfgPersist}, 4'hF);
    check("R6 outputs", {thrHigh, thrLow}, 16'h3CC3);

    // R1 wrong address
    busStart(); sendByte(8'h8A, a); check("R1 nak", a, 0);
    sendByte(8'h02, a); sendByte(8'h55, a); busStop();
    check("R1 ignored", thrHigh, 8'h3C);

    // R2 auto-increment and wrap
    busStart(); sendByte(WR_ADDR, a); sendByte(8'h02, a);
    sendByte(8'h11, a); sendByte(8'h22, a); busStop();
    check("R2 incr", {thrHigh, thrLow}, 16'h1122);
    busStart(); sendByte(WR_ADDR, a); sendByte(8'h07, a);
    sendByte(8'hEE, a); check("R7 ro ack", a, 1); sendByte(8'h05, a); busStop();
    readOne(8'h00, d0); check("R2 wrap write", d0, 8'h05);
    check("R4 enable off", cfgEnable, 0);
    readOne(8'h07, d0); check("R7 write ignored", d0, 8'hAB);

    // R3 multi-byte reads
    readTwo(8'h04, d0, d1); check("R3 sensor lsb", d0, 8'h34); check("R3 sensor msb", d1, 8'h12);
    readTwo(8'h06, d0, d1); check("R7 timer lsb", d0, 8'hCD); check("R7 timer msb", d1, 8'hAB);
    readTwo(8'h07, d0, d1); check("R3 read wrap", d1, 8'h05);

    // R8 command strobes
    s0 = syncCnt; c0 = clrCnt;
    busStart(); sendByte(WR_ADDR, a); sendByte(8'h80, a); check("R8 ack", a, 1); busStop();
    check("R8 sync once", syncCnt - s0, 1); check("R8 no clr", clrCnt - c0, 0);
    s0 = syncCnt; c0 = clrCnt;
    busStart(); sendByte(WR_ADDR, a); sendByte(8'hC0, a); busStop();
    check("R8 both sync", syncCnt - s0, 1); check("R8 both clr", clrCnt - c0, 1);
    s0 = syncCnt;
    writeOne(8'h83, 8'h77, "R8 data ack");
    check("R8 sync with data", syncCnt - s0, 1); check("R8 data written", thrLow, 8'h77);

    // R9 interrupt flag
    intSet = 1; waitc(1); intSet = 0; waitc(2);
    check("R9 set", intFlag, 1);
    readOne(8'h01, d0); check("R5 flag readback", d0, 8'h2F);
    writeOne(8'h01, 8'h00, "R5 write ack");
    readOne(8'h01, d0); check("R5 flag protected", d0, 8'h20);
    c0 = clrCnt;
    busStart(); sendByte(WR_ADDR, a); sendByte(8'h40, a); busStop();
    check("R9 cleared", intFlag, 0); check("R8 clr pulse", clrCnt - c0, 1);

    // R10 values hold across new data
    sensorIn = 16'h5A5A; dataLoad = 1; waitc(1); dataLoad = 0; waitc(50);
    check("R10 hold", {thrHigh, thrLow, cfgGain, cfgPersist}, {8'h11, 8'h77, 4'h0});
    check("R11 sda released", sdaPullLow, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule